// File: doc/BRIEF.md
# I2C Target With Clock Stretching

This block is an I2C bus target (slave) with a 7-bit own address supplied by the host. The SCL and SDA inputs pass through synchronizers. The block finds start and stop conditions, matches the address byte against its own address and then either receives bytes from the bus controller or sends bytes to it. Every event that needs host service (address matched, byte received, byte sent, stop seen) sets a status flag. Each of these flags can raise an interrupt. The block then holds SCL low until the host has served the event, so the bus controller never overruns the host.

Received bytes leave on a valid/ready stream. `rx_valid` stays high, with `rx_data` held, until the host asserts `rx_ready`. Bytes to transmit come in on a second valid/ready stream. `tx_ready` is high only while the target is in transmit direction and its data register is empty. A byte moves on any cycle where valid and ready are both high. The bus is stretched for as long as either stream has not completed its handshake, so stalling a stream is always safe. Control inputs (own address, ACK enable, interrupt enables) and the status outputs are plain levels. Four single-cycle host pulses act on the flags: control-write, status-read, address-flag clear, and the stream handshakes.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset both open-drain enables (`scl_oe`, `sda_oe`) are 0, all six status outputs are 0, `irq`, `tx_ready` and `rx_valid` are 0.
- R2: When `ack_en` is 0, or when the address byte does not carry `own_addr`, the target does not pull SDA low in the ninth clock and leaves `st_addr` at 0. It stays off the bus until the next start or stop.
- R3: The address byte is shifted in MSB first as {address[6:0], rw}. On a match with `ack_en` = 1, the target drives ACK (`sda_oe` = 1) for the ninth clock, sets `st_addr`, and sets `st_dir` to rw (1 = controller reads from the target).
- R4: From the address match until the host pulses `addr_clr`, the target holds SCL low (`scl_oe` = 1).
- R5: In receive, each byte is shifted in MSB first and appears on `rx_data` with `rx_valid` and `st_btf` set. It is acknowledged when `ack_en` = 1. After the ACK clock, SCL is held low until the byte is taken by an `rx_ready` handshake.
- R6: In transmit, `st_txe` is set at the address match. SCL is held low until a byte is accepted on the tx stream. The byte is sent MSB first. When the controller ACKs it, `st_txe` and `st_btf` are set and SCL is held again until the next byte is accepted.
- R7: A NACK from the controller after a transmitted byte ends the transmit phase. SDA and SCL stay released, and later clocks read all ones until the next start or stop.
- R8: A stop after the target was addressed sets `st_stop`. `st_stop` clears only on a `ctrl_wr` pulse that follows a `stat_rd` pulse given while it was set. A `ctrl_wr` alone leaves it set.
- R9: `irq` is 0 whenever `evt_ie` is 0. With `evt_ie` = 1, `irq` follows `st_addr`, `st_btf` or `st_stop`. `st_txe` or `st_rxne` alone raise `irq` only when `buf_ie` is also 1.
- R10: A repeated start during a transfer sends the target back to address reception without setting `st_stop`. A matching address then sets `st_addr` again.
- R11: `tx_ready` is high only while `st_dir` and `st_txe` are both 1. `rx_valid` stays high until a cycle with `rx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data zero) |
| own_addr | input | 7 | Own 7-bit address |
| ack_en | input | 1 | Enables address response and data ACK |
| evt_ie | input | 1 | Event interrupt enable |
| buf_ie | input | 1 | Buffer interrupt enable |
| ctrl_wr | input | 1 | Control-write pulse (second step of stop-flag clear) |
| stat_rd | input | 1 | Status-read pulse (first step of stop-flag clear) |
| addr_clr | input | 1 | Clears the address-matched flag |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Target accepts a transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | 8 | Received byte |
| st_addr | output | 1 | Address matched |
| st_dir | output | 1 | 1 = target transmits |
| st_txe | output | 1 | Transmit data register empty |
| st_rxne | output | 1 | Receive data register full |
| st_btf | output | 1 | Byte transfer finished |
| st_stop | output | 1 | Stop detected |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is exercised with a vector table of address and data pairs. The pairs are a matching address with a mixed-bit byte, all zeros and all ones, a neighbouring address that differs only in bit 0, and a matching address with ACK disabled. Together they separate address compare, ACK gating and bit ordering. The transmit path sends two distinct bytes, the first ACKed and the second NACKed, which shows MSB-first shifting and the release after NACK. Directed cases cover the interrupt enables, the two-step stop-flag clear and a repeated start. In each of them the bench watches whether SCL is held, to confirm that stretching starts and ends on the right host action.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AHOLD,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_RHOLD,
    ST_TXLOAD,
    ST_TX,
    ST_TACK,
    ST_WAIT
  } bus_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] now_o,
  output logic [LINES-1:0] prev_o
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              last;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '1;
          last  <= 1'b1;
        end else begin
          chain <= {chain[STAGES-2:0], raw_i[g]};
          last  <= chain[STAGES-1];
        end
      end
      assign now_o[g]  = chain[STAGES-1];
      assign prev_o[g] = last;
    end
  endgenerate
endmodule

// File: rtl/i2c_tgt_bus.sv
module i2c_tgt_bus
  import i2c_tgt_pkg::*;
#(
  parameter int BITS = BYTE_BITS,
  parameter int AW   = ADDR_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_q,
  input  logic            scl_p,
  input  logic            sda_q,
  input  logic            sda_p,
  input  logic [AW-1:0]   own_addr,
  input  logic            ack_en,
  input  logic            addr_flag,
  input  logic            dir_flag,
  input  logic            txe_flag,
  input  logic            btf_flag,
  input  logic [BITS-1:0] tx_byte,
  output logic            ev_match,
  output logic            ev_dir,
  output logic            ev_rx,
  output logic [BITS-1:0] rx_byte,
  output logic            ev_txd,
  output logic            ev_stop,
  output logic            scl_oe,
  output logic            sda_oe
);
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  bus_state_t       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [BITS-1:0]  sr, sr_n;
  logic             sda_q_r, sda_n;
  logic             active, active_n;
  logic             mack, mack_n;

  logic start_c, stop_c, rise, fall;
  assign start_c = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_c  = scl_q & scl_p & ~sda_p & sda_q;
  assign rise    = scl_q & ~scl_p;
  assign fall    = ~scl_q & scl_p;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    sr_n     = sr;
    sda_n    = sda_q_r;
    active_n = active;
    mack_n   = mack;
    ev_match = 1'b0;
    ev_dir   = sr[0];
    ev_rx    = 1'b0;
    ev_txd   = 1'b0;
    ev_stop  = 1'b0;
    if (stop_c) begin
      state_n  = ST_IDLE;
      sda_n    = 1'b0;
      ev_stop  = active;
      active_n = 1'b0;
    end else if (start_c) begin
      state_n  = ST_ADDR;
      cnt_n    = '0;
      sda_n    = 1'b0;
      active_n = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (rise) begin
            sr_n  = {sr[BITS-2:0], sda_q};
            cnt_n = cnt + 1'b1;
          end else if (fall && cnt == FULL) begin
            if (ack_en && sr[BITS-1:1] == own_addr) begin
              ev_match = 1'b1;
              sda_n    = 1'b1;
              active_n = 1'b1;
              state_n  = ST_AHOLD;
            end else begin
              state_n = ST_WAIT;
            end
          end
        end
        ST_AHOLD: if (!addr_flag) state_n = ST_AACK;
        ST_AACK: begin
          if (fall) begin
            sda_n   = 1'b0;
            cnt_n   = '0;
            state_n = dir_flag ? ST_TXLOAD : ST_RX;
          end
        end
        ST_RX: begin
          if (rise) begin
            sr_n  = {sr[BITS-2:0], sda_q};
            cnt_n = cnt + 1'b1;
          end else if (fall && cnt == FULL) begin
            ev_rx   = 1'b1;
            sda_n   = ack_en;
            state_n = ST_RACK;
          end
        end
        ST_RACK: begin
          if (fall) begin
            sda_n   = 1'b0;
            state_n = ST_RHOLD;
          end
        end
        ST_RHOLD: begin
          if (!btf_flag) begin
            cnt_n   = '0;
            state_n = ST_RX;
          end
        end
        ST_TXLOAD: begin
          if (!txe_flag) begin
            sr_n    = tx_byte;
            sda_n   = ~tx_byte[BITS-1];
            cnt_n   = '0;
            state_n = ST_TX;
          end
        end
        ST_TX: begin
          if (fall) begin
            cnt_n = cnt + 1'b1;
            if (cnt == LAST) begin
              sda_n   = 1'b0;
              state_n = ST_TACK;
            end else begin
              sr_n  = {sr[BITS-2:0], 1'b0};
              sda_n = ~sr[BITS-2];
            end
          end
        end
        ST_TACK: begin
          if (rise) begin
            mack_n = ~sda_q;
          end else if (fall) begin
            if (mack) begin
              ev_txd  = 1'b1;
              state_n = ST_TXLOAD;
            end else begin
              state_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sr      <= '0;
      sda_q_r <= 1'b0;
      active  <= 1'b0;
      mack    <= 1'b0;
    end else begin
      state   <= state_n;
      cnt     <= cnt_n;
      sr      <= sr_n;
      sda_q_r <= sda_n;
      active  <= active_n;
      mack    <= mack_n;
    end
  end

  assign rx_byte = sr;
  assign sda_oe  = sda_q_r;
  assign scl_oe  = (state == ST_AHOLD) || (state == ST_RHOLD) || (state == ST_TXLOAD);
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_match,
  input  logic            ev_dir,
  input  logic            ev_rx,
  input  logic [BITS-1:0] rx_byte,
  input  logic            ev_txd,
  input  logic            ev_stop,
  input  logic            addr_clr,
  input  logic            stat_rd,
  input  logic            ctrl_wr,
  input  logic            evt_ie,
  input  logic            buf_ie,
  input  logic            tx_valid,
  input  logic [BITS-1:0] tx_data,
  output logic            tx_ready,
  input  logic            rx_ready,
  output logic            rx_valid,
  output logic [BITS-1:0] data_reg,
  output logic            addr_f,
  output logic            dir_f,
  output logic            txe_f,
  output logic            rxne_f,
  output logic            btf_f,
  output logic            stop_f,
  output logic            irq
);
  logic rd_seen;
  logic tx_fire, rx_fire;

  assign tx_ready = txe_f & dir_f;
  assign tx_fire  = tx_valid & tx_ready;
  assign rx_valid = rxne_f;
  assign rx_fire  = rx_ready & rxne_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_f   <= 1'b0;
      dir_f    <= 1'b0;
      txe_f    <= 1'b0;
      rxne_f   <= 1'b0;
      btf_f    <= 1'b0;
      stop_f   <= 1'b0;
      rd_seen  <= 1'b0;
      data_reg <= '0;
    end else begin
      if (addr_clr) addr_f <= 1'b0;
      if (tx_fire) begin
        data_reg <= tx_data;
        txe_f    <= 1'b0;
        btf_f    <= 1'b0;
      end
      if (rx_fire) begin
        rxne_f <= 1'b0;
        btf_f  <= 1'b0;
      end
      if (ev_match) begin
        addr_f <= 1'b1;
        dir_f  <= ev_dir;
        txe_f  <= ev_dir;
        btf_f  <= 1'b0;
      end
      if (ev_rx) begin
        data_reg <= rx_byte;
        rxne_f   <= 1'b1;
        btf_f    <= 1'b1;
      end
      if (ev_txd) begin
        txe_f <= 1'b1;
        btf_f <= 1'b1;
      end
      if (stat_rd && stop_f) rd_seen <= 1'b1;
      if (ctrl_wr && rd_seen) begin
        stop_f  <= 1'b0;
        rd_seen <= 1'b0;
      end
      if (ev_stop) begin
        stop_f  <= 1'b1;
        rd_seen <= 1'b0;
        dir_f   <= 1'b0;
        txe_f   <= 1'b0;
      end
    end
  end

  assign irq = evt_ie & (addr_f | stop_f | btf_f | (buf_ie & (txe_f | rxne_f)));
endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int BITS        = BYTE_BITS,
  parameter int AW          = ADDR_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  input  logic [AW-1:0]   own_addr,
  input  logic            ack_en,
  input  logic            evt_ie,
  input  logic            buf_ie,
  input  logic            ctrl_wr,
  input  logic            stat_rd,
  input  logic            addr_clr,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [BITS-1:0] tx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [BITS-1:0] rx_data,
  output logic            st_addr,
  output logic            st_dir,
  output logic            st_txe,
  output logic            st_rxne,
  output logic            st_btf,
  output logic            st_stop,
  output logic            irq
);
  logic [1:0] ln_now, ln_prev;
  logic ev_match, ev_dir, ev_rx, ev_txd, ev_stop;
  logic [BITS-1:0] rx_byte, data_reg;

  i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .now_o  (ln_now),
    .prev_o (ln_prev)
  );

  i2c_tgt_bus #(.BITS(BITS), .AW(AW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_q     (ln_now[0]),
    .scl_p     (ln_prev[0]),
    .sda_q     (ln_now[1]),
    .sda_p     (ln_prev[1]),
    .own_addr  (own_addr),
    .ack_en    (ack_en),
    .addr_flag (st_addr),
    .dir_flag  (st_dir),
    .txe_flag  (st_txe),
    .btf_flag  (st_btf),
    .tx_byte   (data_reg),
    .ev_match  (ev_match),
    .ev_dir    (ev_dir),
    .ev_rx     (ev_rx),
    .rx_byte   (rx_byte),
    .ev_txd    (ev_txd),
    .ev_stop   (ev_stop),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  i2c_tgt_regs #(.BITS(BITS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_match (ev_match),
    .ev_dir   (ev_dir),
    .ev_rx    (ev_rx),
    .rx_byte  (rx_byte),
    .ev_txd   (ev_txd),
    .ev_stop  (ev_stop),
    .addr_clr (addr_clr),
    .stat_rd  (stat_rd),
    .ctrl_wr  (ctrl_wr),
    .evt_ie   (evt_ie),
    .buf_ie   (buf_ie),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .data_reg (data_reg),
    .addr_f   (st_addr),
    .dir_f    (st_dir),
    .txe_f    (st_txe),
    .rxne_f   (st_rxne),
    .btf_f    (st_btf),
    .stop_f   (st_stop),
    .irq      (irq)
  );

  assign rx_data = data_reg;
endmodule

// File: rtl/i2c_target_stretch_chk.sv
module i2c_target_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic evt_ie,
  input logic ctrl_wr,
  input logic rx_valid,
  input logic rx_ready,
  input logic st_addr,
  input logic st_stop,
  input logic irq
);
  AST_ADDR_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    st_addr |-> scl_oe); // R4

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_stop && !ctrl_wr) |=> st_stop); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ie |-> !irq); // R9

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid); // R11
endmodule

bind i2c_target_stretch i2c_target_stretch_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_oe   (scl_oe),
  .evt_ie   (evt_ie),
  .ctrl_wr  (ctrl_wr),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .st_addr  (st_addr),
  .st_stop  (st_stop),
  .irq      (irq)
);

// File: tb/i2c_target_stretch_bench.sv
module i2c_target_stretch_bench;
  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int NV = 5;
  // {addr[6:0], data[7:0], ack_en, expect_ack}
  localparam logic [16:0] VEC [NV] = '{
    {7'h5A, 8'hC3, 1'b1, 1'b1},
    {7'h5B, 8'h11, 1'b1, 1'b0},
    {7'h5A, 8'h3C, 1'b0, 1'b0},
    {7'h5A, 8'h00, 1'b1, 1'b1},
    {7'h5A, 8'hFF, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic ack_en = 1'b0, evt_ie = 1'b0, buf_ie = 1'b0;
  logic ctrl_wr = 1'b0, stat_rd = 1'b0, addr_clr = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid;
  logic [7:0] rx_data;
  logic st_addr, st_dir, st_txe, st_rxne, st_btf, st_stop, irq;
  logic scl_line, sda_line;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_target_stretch u_i2c_target_stretch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .ack_en(ack_en),
    .evt_ie(evt_ie), .buf_ie(buf_ie), .ctrl_wr(ctrl_wr), .stat_rd(stat_rd),
    .addr_clr(addr_clr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .st_addr(st_addr), .st_dir(st_dir), .st_txe(st_txe),
    .st_rxne(st_rxne), .st_btf(st_btf), .st_stop(st_stop), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise();
    int n = 0;
    m_scl = 1'b1;
    while (!scl_line && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, "stretch-timeout", 32'(n), 32'd5000);
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(H);
  endtask

  task automatic m_rstart();
    m_sda = 1'b1; wt(H);
    raise(); wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(H);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wt(H);
    raise(); wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic m_wbits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(H);
      raise(); wt(H);
      m_scl = 1'b0; wt(H);
    end
    m_sda = 1'b1;
  endtask

  task automatic m_rbits(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wt(H);
      raise(); wt(H / 2);
      b[i] = sda_line; wt(H / 2);
      m_scl = 1'b0; wt(H);
    end
  endtask

  task automatic m_ackclk(output logic a);
    m_sda = 1'b1; wt(H);
    raise(); wt(H / 2);
    a = sda_line; wt(H / 2);
    m_scl = 1'b0; wt(H);
  endtask

  task automatic m_sendack(input logic nack);
    m_sda = nack; wt(H);
    raise(); wt(H);
    m_scl = 1'b0; wt(H);
    m_sda = 1'b1;
  endtask

  task automatic pulse_addr_clr();
    addr_clr = 1'b1; wt(1); addr_clr = 1'b0;
  endtask

  task automatic pulse_rx();
    rx_ready = 1'b1; wt(1); rx_ready = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_data = d; tx_valid = 1'b1; wt(1); tx_valid = 1'b0;
  endtask

  task automatic clear_stop();
    stat_rd = 1'b1; wt(1); stat_rd = 1'b0; wt(1);
    ctrl_wr = 1'b1; wt(1); ctrl_wr = 1'b0; wt(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] r;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    chk({scl_oe, sda_oe, irq, tx_ready, rx_valid} == 5'b0, "R1 outputs", {scl_oe, sda_oe, irq, tx_ready, rx_valid}, 0);
    chk({st_addr, st_dir, st_txe, st_rxne, st_btf, st_stop} == 6'b0, "R1 status",
        {st_addr, st_dir, st_txe, st_rxne, st_btf, st_stop}, 0);

    // Receive vector table: R2 R3 R4 R5 R11 R8
    for (int i = 0; i < NV; i++) begin
      logic [6:0] va;
      logic [7:0] vd;
      logic ve;
      va = VEC[i][16:10]; vd = VEC[i][9:2]; ack_en = VEC[i][1]; ve = VEC[i][0];
      m_start();
      m_wbits({va, 1'b0});
      wt(H);
      chk(sda_oe == ve, "R3/R2 address ack drive", sda_oe, ve);
      chk(st_addr == ve, "R3/R2 address flag", st_addr, ve);
      if (ve) begin
        chk(st_dir == 1'b0, "R3 direction write", st_dir, 0);
        chk(scl_oe == 1'b1, "R4 stretch after match", scl_oe, 1);
        pulse_addr_clr();
        wt(4);
        chk(scl_oe == 1'b0, "R4 release after addr_clr", scl_oe, 0);
        m_ackclk(a);
        chk(a == 1'b0, "R3 ack seen on bus", a, 0);
        m_wbits(vd);
        wt(H);
        chk(rx_valid && st_btf && rx_data == vd, "R5 received byte", {rx_valid, st_btf, rx_data}, {2'b11, vd});
        m_ackclk(a);
        chk(a == 1'b0, "R5 data ack", a, 0);
        wt(H);
        chk(scl_oe == 1'b1 && rx_valid, "R5 stretch until consumed", {scl_oe, rx_valid}, 2'b11);
        pulse_rx();
        wt(4);
        chk(scl_oe == 1'b0 && !rx_valid && !st_btf, "R11 rx handshake releases", {scl_oe, rx_valid, st_btf}, 0);
        m_stop();
        chk(st_stop == 1'b1, "R8 stop after addressed", st_stop, 1);
        clear_stop();
        chk(st_stop == 1'b0, "R8 stop cleared by read then write", st_stop, 0);
      end else begin
        m_ackclk(a);
        chk(a == 1'b1, "R2 no ack", a, 1);
        m_stop();
        chk(st_stop == 1'b0, "R8 no stop flag when not addressed", st_stop, 0);
      end
    end

    // Transmit: R6 R7 R9 R11 R8
    ack_en = 1'b1; evt_ie = 1'b1; buf_ie = 1'b0;
    m_start();
    m_wbits({OWN, 1'b1});
    wt(H);
    chk(st_addr && st_dir && st_txe, "R6 read match flags", {st_addr, st_dir, st_txe}, 3'b111);
    chk(tx_ready == 1'b1, "R11 tx_ready when empty in transmit", tx_ready, 1);
    chk(irq == 1'b1, "R9 irq on address event", irq, 1);
    evt_ie = 1'b0; wt(2);
    chk(irq == 1'b0, "R9 irq masked by evt_ie", irq, 0);
    evt_ie = 1'b1;
    pulse_addr_clr();
    wt(4);
    chk(irq == 1'b0, "R9 txe needs buf_ie", irq, 0);
    buf_ie = 1'b1; wt(2);
    chk(irq == 1'b1, "R9 txe irq with buf_ie", irq, 1);
    buf_ie = 1'b0;
    m_ackclk(a);
    chk(a == 1'b0, "R3 read address ack", a, 0);
    wt(H);
    chk(scl_oe == 1'b1, "R6 stretch until byte loaded", scl_oe, 1);
    push_tx(8'hA5);
    wt(4);
    chk(scl_oe == 1'b0 && !tx_ready, "R6 release after load", {scl_oe, tx_ready}, 0);
    m_rbits(r);
    chk(r == 8'hA5, "R6 first byte MSB first", r, 8'hA5);
    m_sendack(1'b0);
    wt(H);
    chk(st_btf && st_txe && scl_oe, "R6 byte done stretch", {st_btf, st_txe, scl_oe}, 3'b111);
    push_tx(8'h5C);
    m_rbits(r);
    chk(r == 8'h5C, "R6 second byte", r, 8'h5C);
    m_sendack(1'b1);
    wt(H);
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R7 released after nack", {sda_oe, scl_oe}, 0);
    m_rbits(r);
    chk(r == 8'hFF, "R7 bus stays released", r, 8'hFF);
    m_stop();
    chk(st_stop == 1'b1, "R8 stop after transmit", st_stop, 1);
    ctrl_wr = 1'b1; wt(1); ctrl_wr = 1'b0; wt(2);
    chk(st_stop == 1'b1, "R8 ctrl_wr alone keeps flag", st_stop, 1);
    clear_stop();
    chk(st_stop == 1'b0, "R8 two-step clear", st_stop, 0);

    // Repeated start: R10
    m_start();
    m_wbits({OWN, 1'b0});
    wt(H);
    pulse_addr_clr();
    m_ackclk(a);
    m_wbits(8'h77);
    m_ackclk(a);
    wt(H);
    pulse_rx();
    wt(4);
    m_rstart();
    chk(st_stop == 1'b0, "R10 no stop flag on repeated start", st_stop, 0);
    m_wbits({OWN, 1'b0});
    wt(H);
    chk(st_addr && sda_oe, "R10 address matched after repeated start", {st_addr, sda_oe}, 2'b11);
    pulse_addr_clr();
    m_ackclk(a);
    m_stop();
    chk(st_stop == 1'b1, "R10 stop after repeated transfer", st_stop, 1);
    clear_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule